// File: doc/BRIEF.md
# Single-Port Tightly Coupled Memory Arbiter

This block lets a processor's instruction-fetch port and its data port share one single-port tightly coupled memory that performs at most one access per clock. Each port raises a request with an address; the data port also carries a write flag and write data. The arbiter steers the memory address, write data, enable and write strobe. It drives a stall back to each port and returns read data to the port that owned each read.

Data writes are never applied in the cycle they are accepted. They are captured in a one-entry write register and applied on the following clock, so that the write address and write data reach the memory together. That deferred write, together with a registered record of the last data-port grant, produces a fixed stall schedule. A four-state machine (`ST_IDLE`, `ST_WRITE`, `ST_RDHOLD`, `ST_FWAIT`) encodes the schedule. `ST_WRITE` means the captured write owns the memory this cycle. `ST_RDHOLD` means the memory path is still steered to the data port after a lone data read. `ST_FWAIT` means a fetch was held back last cycle and now has priority. Transitions: any accepted write goes to `ST_WRITE`. Otherwise a fetch stalled outside `ST_WRITE` goes to `ST_FWAIT`. Otherwise a data read granted with no fetch pending goes to `ST_RDHOLD`. Everything else returns to `ST_IDLE`. A synchronous reset forces `ST_IDLE`, clears the write register and clears the read-owner record.

Top module: `tcm_arbiter`

## Requirements
- R1: During and after a synchronous reset, the state is `ST_IDLE`, no write is pending, `ram_we` is low, and both read-valid outputs are low on the cycle after reset.
- R2: A data write accepted in cycle t (`dp_req`=1, `dp_we`=1, `dp_stall`=0) is driven onto the memory in cycle t+1 with `ram_en`=1, `ram_we`=1, and the address and data presented in cycle t.
- R3: In the cycle after an accepted write, the memory performs that write. A fetch or data read requested in that cycle stalls. A new data write in that cycle is accepted without stall.
- R4: When a fetch and a data read are both requested while the memory is free and the state is not `ST_FWAIT`, the data read is granted and the fetch stalls. In `ST_FWAIT` the fetch is granted and the data read stalls.
- R5: After a data read is granted with no fetch requested, a fetch requested alone in the next cycle stalls for exactly one cycle.
- R6: A fetch and a data write requested in the same cycle with the memory free (state `ST_IDLE` or `ST_FWAIT`) are both served with no stall. The fetch's following request then stalls for one cycle while the write is applied.
- R7: A data write followed by a cycle with both a fetch and a data read costs the fetch two stall cycles and the data read one.
- R8: Read data on `ram_rdata` is marked valid one cycle after the read address is applied, only on the port that owned the read (`fe_rvalid` or `dp_rvalid`, never both). The value returned is the memory content at that address, including any earlier deferred write.
- R9: A stall output is asserted only while its own port requests. The memory is driven by at most one source per cycle.
- R10: A fetch requested alone while the memory is free and the state is not `ST_RDHOLD` is granted with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fe_req | input | 1 | Fetch request |
| fe_addr | input | AW | Fetch word address |
| fe_stall | output | 1 | Fetch must hold its request this cycle |
| fe_rdata | output | DW | Fetch read data |
| fe_rvalid | output | 1 | Fetch read data valid |
| dp_req | input | 1 | Data-port request |
| dp_we | input | 1 | Data-port write flag (1 = write, 0 = read) |
| dp_addr | input | AW | Data-port word address |
| dp_wdata | input | DW | Data-port write data |
| dp_stall | output | 1 | Data port must hold its request this cycle |
| dp_rdata | output | DW | Data-port read data |
| dp_rvalid | output | 1 | Data-port read data valid |
| ram_en | output | 1 | Memory access enable |
| ram_we | output | 1 | Memory write strobe |
| ram_addr | output | AW | Memory address |
| ram_wdata | output | DW | Memory write data |
| ram_rdata | input | DW | Memory read data, one cycle after the address |

## Verification
The assertions assume that a port seeing its stall keeps its request, address and write flag unchanged into the next cycle. They also assume the memory returns read data on the clock after a read address. The bench honours the first by latching each port's stall at the sampling point and re-presenting the same request while it was stalled. Only unstalled ports draw fresh random or directed values. A behavioural memory in the bench registers its read output, which meets the second assumption.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

    // Arbitration state: what owns or steers the memory this cycle
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_RDHOLD = 2'd2,
        ST_FWAIT  = 2'd3
    } arb_state_e;

    // Owner of the read issued last cycle
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_FETCH = 2'd1,
        OWN_DATA  = 2'd2
    } rd_owner_e;

endpackage

// File: rtl/tcm_wr_pipe.sv
module tcm_wr_pipe #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          pend,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            pend <= load;
            if (load) begin
                addr_q <= addr_in;
                data_q <= data_in;
            end
        end
    end

endmodule

// File: rtl/tcm_arb_fsm.sv
module tcm_arb_fsm
    import tcm_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic f_req,
    input  logic d_req,
    input  logic d_we,
    output logic f_stall,
    output logic d_stall,
    output logic g_wr,
    output logic g_dr,
    output logic g_if,
    output logic wr_load
);

    arb_state_e state, state_nx;
    logic rd_req, wr_req;

    assign rd_req = d_req & ~d_we;
    assign wr_req = d_req & d_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // outputs and next state
    always_comb begin
        f_stall  = 1'b0;
        d_stall  = 1'b0;
        g_wr     = 1'b0;
        g_dr     = 1'b0;
        g_if     = 1'b0;
        wr_load  = wr_req;
        unique case (state)
            ST_WRITE: begin
                g_wr    = 1'b1;
                f_stall = f_req;
                d_stall = rd_req;
            end
            ST_IDLE, ST_RDHOLD, ST_FWAIT: begin
                if (rd_req && f_req) begin
                    if (state == ST_FWAIT) begin
                        g_if    = 1'b1;
                        d_stall = 1'b1;
                    end else begin
                        g_dr    = 1'b1;
                        f_stall = 1'b1;
                    end
                end else if (rd_req) begin
                    g_dr = 1'b1;
                end else if (f_req) begin
                    if (state == ST_RDHOLD) f_stall = 1'b1;
                    else                    g_if    = 1'b1;
                end
            end
        endcase

        if (wr_load)                           state_nx = ST_WRITE;
        else if (f_stall && state != ST_WRITE) state_nx = ST_FWAIT;
        else if (g_dr && !f_req)               state_nx = ST_RDHOLD;
        else                                   state_nx = ST_IDLE;
    end

    // R9: a stall only goes to a requesting port
    a_r9_fetch_stall_req: assert property (@(posedge clk) disable iff (rst)
        f_stall |-> f_req);
    a_r9_data_stall_req: assert property (@(posedge clk) disable iff (rst)
        d_stall |-> d_req);
    // R9: one memory source per cycle
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({g_wr, g_dr, g_if}));
    // R4: a fetch that lost to a data read wins the next cycle
    a_r4_fetch_next: assert property (@(posedge clk) disable iff (rst)
        (f_req && rd_req && f_stall && state != ST_WRITE) |=> (!f_req || !f_stall));
    // R1: reset leaves the idle state
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

endmodule

// File: rtl/tcm_rd_route.sv
module tcm_rd_route
    import tcm_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic g_if,
    input  logic g_dr,
    output logic f_rvalid,
    output logic d_rvalid
);

    rd_owner_e owner;

    always_ff @(posedge clk) begin
        if (rst)       owner <= OWN_NONE;
        else if (g_dr) owner <= OWN_DATA;
        else if (g_if) owner <= OWN_FETCH;
        else           owner <= OWN_NONE;
    end

    assign f_rvalid = (owner == OWN_FETCH);
    assign d_rvalid = (owner == OWN_DATA);

    // R8: a granted read is returned on the next cycle
    a_r8_return_next: assert property (@(posedge clk) disable iff (rst)
        (g_if || g_dr) |=> (f_rvalid || d_rvalid));

endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter #(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fe_req,
    input  logic [AW-1:0] fe_addr,
    output logic          fe_stall,
    output logic [DW-1:0] fe_rdata,
    output logic          fe_rvalid,
    input  logic          dp_req,
    input  logic          dp_we,
    input  logic [AW-1:0] dp_addr,
    input  logic [DW-1:0] dp_wdata,
    output logic          dp_stall,
    output logic [DW-1:0] dp_rdata,
    output logic          dp_rvalid,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);

    logic          g_wr, g_dr, g_if, wr_load;
    logic          wp_pend;
    logic [AW-1:0] wp_addr;
    logic [DW-1:0] wp_data;

    tcm_arb_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .f_req   (fe_req),
        .d_req   (dp_req),
        .d_we    (dp_we),
        .f_stall (fe_stall),
        .d_stall (dp_stall),
        .g_wr    (g_wr),
        .g_dr    (g_dr),
        .g_if    (g_if),
        .wr_load (wr_load)
    );

    tcm_wr_pipe #(.AW(AW), .DW(DW)) u_wpipe (
        .clk     (clk),
        .rst     (rst),
        .load    (wr_load),
        .addr_in (dp_addr),
        .data_in (dp_wdata),
        .pend    (wp_pend),
        .addr_q  (wp_addr),
        .data_q  (wp_data)
    );

    tcm_rd_route u_route (
        .clk      (clk),
        .rst      (rst),
        .g_if     (g_if),
        .g_dr     (g_dr),
        .f_rvalid (fe_rvalid),
        .d_rvalid (dp_rvalid)
    );

    always_comb begin
        ram_en    = g_wr | g_dr | g_if;
        ram_we    = g_wr;
        ram_wdata = wp_data;
        if (g_wr)      ram_addr = wp_addr;
        else if (g_dr) ram_addr = dp_addr;
        else           ram_addr = fe_addr;
    end

    assign fe_rdata = ram_rdata;
    assign dp_rdata = ram_rdata;

    // R2: an accepted write lands on the memory one cycle later, intact
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (dp_req && dp_we && !dp_stall) |=>
            (ram_en && ram_we && ram_addr == $past(dp_addr) && ram_wdata == $past(dp_wdata)));
    // R2: the write register and the write-owning state agree
    a_r2_pipe_in_step: assert property (@(posedge clk) disable iff (rst)
        wp_pend == g_wr);
    // R3: reads are held off while the deferred write runs
    a_r3_reads_blocked: assert property (@(posedge clk) disable iff (rst)
        (dp_req && dp_we && !dp_stall) |=> ((!fe_req || fe_stall) && (dp_we || !dp_req || dp_stall)));
    // R8: only one port sees valid read data
    a_r8_one_owner: assert property (@(posedge clk) disable iff (rst)
        !(fe_rvalid && dp_rvalid));
    // R1: nothing is written or returned right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!ram_we && !fe_rvalid && !dp_rvalid));
    // input contract: a stalled port holds its request
    a_in_fetch_hold: assert property (@(posedge clk) disable iff (rst)
        fe_stall |=> (fe_req && $stable(fe_addr)));
    a_in_data_hold: assert property (@(posedge clk) disable iff (rst)
        dp_stall |=> (dp_req && $stable(dp_addr) && $stable(dp_we)));

endmodule

// File: tb/tcm_arbiter_tb_top.sv
module tcm_arbiter_tb_top;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fe_req = 1'b0;
    logic [AW-1:0] fe_addr = '0;
    logic          fe_stall;
    logic [DW-1:0] fe_rdata;
    logic          fe_rvalid;
    logic          dp_req = 1'b0;
    logic          dp_we = 1'b0;
    logic [AW-1:0] dp_addr = '0;
    logic [DW-1:0] dp_wdata = '0;
    logic          dp_stall;
    logic [DW-1:0] dp_rdata;
    logic          dp_rvalid;
    logic          ram_en;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata = '0;

    always #10 clk = ~clk;

    tcm_arbiter #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst),
        .fe_req(fe_req), .fe_addr(fe_addr), .fe_stall(fe_stall),
        .fe_rdata(fe_rdata), .fe_rvalid(fe_rvalid),
        .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_stall(dp_stall), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // behavioural single-port memory, registered read
    logic [DW-1:0] ram   [NW];
    logic [DW-1:0] shadow[NW];

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram[ram_addr] <= ram_wdata;
            else        ram_rdata     <= ram[ram_addr];
        end
    end

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference flags describing the previous cycle
    bit            m_wr;      // write accepted last cycle
    bit            m_hold;    // lone data read granted last cycle
    bit            m_fwait;   // fetch lost to data last cycle
    logic [AW-1:0] m_wa;
    logic [DW-1:0] m_wd;
    bit            x_fv, x_dv;
    logic [DW-1:0] x_fd, x_dd;
    bit            last_fs, last_ds;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string pick_tag(bit w, bit h, bit fw, bit f, bit dr, bit dw);
        if (w && f && dr)  return "R7";
        if (w)             return "R3";
        if (f && dr)       return "R4";
        if (h && f)        return "R5";
        if (f && dw && !h) return "R6";
        if (f && !fw)      return "R10";
        return "R9";
    endfunction

    task automatic step(input bit nf, input logic [AW-1:0] nfa, input bit nd, input bit nwe,
                        input logic [AW-1:0] nda, input logic [DW-1:0] nwd);
        bit f, dr, dw, es_f, es_d;
        string tag;
        @(negedge clk);
        // returns from last cycle's read
        chk("R8", {31'd0, fe_rvalid}, {31'd0, x_fv});
        chk("R8", {31'd0, dp_rvalid}, {31'd0, x_dv});
        if (x_fv) chk("R8", fe_rdata, x_fd);
        if (x_dv) chk("R8", dp_rdata, x_dd);
        // a stalled port re-presents its request
        if (!last_fs) begin fe_req = nf; fe_addr = nfa; end
        if (!last_ds) begin dp_req = nd; dp_we = nwe; dp_addr = nda; dp_wdata = nwd; end
        #1;
        f  = fe_req;
        dr = dp_req && !dp_we;
        dw = dp_req && dp_we;
        es_f = 1'b0;
        es_d = 1'b0;
        if (m_wr) begin
            es_f = f;
            es_d = dr;
        end else if (f && dr) begin
            es_f = !m_fwait;
            es_d = m_fwait;
        end else if (f) begin
            es_f = m_hold;
        end
        tag = pick_tag(m_wr, m_hold, m_fwait, f, dr, dw);
        chk(tag, {31'd0, fe_stall}, {31'd0, es_f});
        chk(tag, {31'd0, dp_stall}, {31'd0, es_d});
        if (m_wr) begin
            chk("R2", {31'd0, ram_we}, 32'd1);
            chk("R2", {24'd0, ram_addr}, {24'd0, m_wa});
            chk("R2", ram_wdata, m_wd);
            shadow[m_wa] = m_wd;
        end else begin
            chk("R9", {31'd0, ram_we}, 32'd0);
        end
        x_fv = f && !es_f;
        x_fd = shadow[fe_addr];
        x_dv = dr && !es_d;
        x_dd = shadow[dp_addr];
        m_fwait = !m_wr && !dw && f && es_f;
        m_hold  = !m_wr && !dw && dr && !es_d && !f;
        m_wr    = dw;
        if (dw) begin m_wa = dp_addr; m_wd = dp_wdata; end
        last_fs = fe_stall;
        last_ds = dp_stall;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            ram[i]    = 32'h1000_0000 + i * 7;
            shadow[i] = 32'h1000_0000 + i * 7;
        end
        m_wr = 0; m_hold = 0; m_fwait = 0; m_wa = '0; m_wd = '0;
        x_fv = 0; x_dv = 0; x_fd = '0; x_dd = '0;
        last_fs = 0; last_ds = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state visible at the ports
        chk("R1", {31'd0, ram_we}, 32'd0);
        chk("R1", {31'd0, fe_rvalid}, 32'd0);
        chk("R1", {31'd0, dp_rvalid}, 32'd0);
        chk("R1", {30'd0, fe_stall, dp_stall}, 32'd0);

        // R10: lone fetch
        step(1'b1, 8'h03, 1'b0, 1'b0, '0, '0);
        idle();
        // R6: fetch and write together, then a fetch
        step(1'b1, 8'h04, 1'b1, 1'b1, 8'h05, 32'hCAFE_0001);
        step(1'b1, 8'h05, 1'b0, 1'b0, '0, '0);
        step(1'b0, '0, 1'b0, 1'b0, '0, '0);
        idle();
        // R5: lone data read then lone fetch
        step(1'b0, '0, 1'b1, 1'b0, 8'h05, '0);
        step(1'b1, 8'h06, 1'b0, 1'b0, '0, '0);
        step(1'b1, 8'h06, 1'b0, 1'b0, '0, '0);
        idle();
        // R7: write then fetch plus data read
        step(1'b0, '0, 1'b1, 1'b1, 8'h09, 32'hBEEF_0009);
        step(1'b1, 8'h0A, 1'b1, 1'b0, 8'h09, '0);
        repeat (3) step(1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R4: fetch plus read from idle
        step(1'b1, 8'h01, 1'b1, 1'b0, 8'h02, '0);
        repeat (2) idle();
        // R3: back-to-back writes, then a read of the second
        step(1'b0, '0, 1'b1, 1'b1, 8'h0B, 32'h1111_2222);
        step(1'b0, '0, 1'b1, 1'b1, 8'h0C, 32'h3333_4444);
        step(1'b0, '0, 1'b1, 1'b0, 8'h0C, '0);
        repeat (3) idle();

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) != 0, AW'($urandom % 16),
                 ($urandom % 3) != 0, ($urandom % 2) == 1,
                 AW'($urandom % 16), $urandom);
        end
        repeat (3) idle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule